// File: doc/BRIEF.md
# Restoring Sequential Unsigned Divider

This block divides one unsigned integer by another and returns both the quotient and the remainder. It takes one step per clock and yields one quotient bit per step. A remainder register is shifted left by one position each cycle. Its vacated low bit takes the top bit of a dividend shift register, which in turn shifts left and fills with zero. The block subtracts the divisor from the shifted remainder. A result that does not go negative means the remainder was at least the divisor: the difference is kept and a 1 enters the low end of the quotient. A negative result leaves the shifted remainder as it was and enters a 0. After WIDTH steps the quotient and remainder are complete.

The interface is a start/busy/done handshake. A start pulse is accepted only while the block is not busy. A zero divisor skips the iteration: the result comes back at once with a flag raised, the quotient all ones and the remainder equal to the dividend. Between operations the results stay on the output ports until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held and after it is released, busy_o, done_o and div_zero_o are 0 and quotient_o and remainder_o are 0.
- R2: start_i is accepted only on a clock edge where busy_o is 0; a start_i pulse while busy_o is 1 changes neither the result nor the cycle in which done_o rises.
- R3: For a nonzero divisor accepted at clock edge k, busy_o is 1 after edges k to k+WIDTH-1 and done_o is 1 after edge k+WIDTH, with busy_o and done_o never high together.
- R4: When done_o rises for a nonzero divisor, quotient_o equals floor(dividend/divisor) and remainder_o equals dividend mod divisor, so that dividend = quotient*divisor + remainder with remainder < divisor.
- R5: done_o is high for exactly one cycle per operation unless a new start is accepted in that cycle.
- R6: After i steps (1 <= i < WIDTH) of an operation, quotient_o equals the top i dividend bits divided by the divisor and remainder_o equals those bits modulo the divisor (the quotient is built MSB first by shifting in at bit 0).
- R7: On the edge that accepts a start with a nonzero divisor, quotient_o and remainder_o are cleared to 0, and div_zero_o is cleared.
- R8: A start with divisor 0 is completed on the accepting edge: done_o and div_zero_o are 1, quotient_o is all ones, remainder_o equals the dividend, and busy_o stays 0.
- R9: After completion quotient_o, remainder_o and div_zero_o hold their values until the next accepted start, and a later accepted nonzero-divisor start clears div_zero_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a division with the operands present |
| dividend_i | input | WIDTH | Unsigned dividend, sampled when the start is accepted |
| divisor_i | input | WIDTH | Unsigned divisor, sampled when the start is accepted |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| div_zero_o | output | 1 | Last accepted operation had a zero divisor |
| quotient_o | output | WIDTH | Quotient (partial while busy) |
| remainder_o | output | WIDTH | Remainder (partial while busy) |

## Verification
The bench builds the divider with WIDTH set to 5, which shrinks the operand space to 1024 pairs so every dividend and divisor combination runs. That range holds every zero-divisor case, all-ones operands and divisors larger than the dividend. Because the width is small, the bench can predict the partial quotient and remainder after each single step and compare them too. Directed scenarios add a start pulse during an operation, result hold after completion and clearing of the zero flag.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/udiv_sub.sv
module udiv_sub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] min_i,
    input  logic [WIDTH-1:0] sub_i,
    output logic [WIDTH-1:0] diff_o,
    output logic             borrow_o
);

    // Two's complement subtract: min + ~sub + 1, ripple carry per bit.
    always_comb begin
        logic c;
        logic nb;
        c = 1'b1;
        diff_o = '0;
        for (int i = 0; i < WIDTH; i++) begin
            nb        = ~sub_i[i];
            diff_o[i] = min_i[i] ^ nb ^ c;
            c         = (min_i[i] & nb) | (min_i[i] & c) | (nb & c);
        end
        borrow_o = ~c;
    end

endmodule

// File: rtl/udiv_stage.sv
module udiv_stage #(
    parameter int WIDTH = 8
) (
    input  logic             active_i,
    input  logic [WIDTH-1:0] rem_i,
    input  logic             msb_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic [WIDTH-1:0] rem_o,
    output logic             qbit_o
);

    localparam int XW = WIDTH + 1;

    logic [XW-1:0] shifted;
    logic [XW-1:0] trial;
    logic [XW-1:0] diff;
    logic          borrow;

    assign shifted = {rem_i, msb_i};
    assign trial   = {1'b0, divisor_i};

    udiv_sub #(.WIDTH(XW)) i_sub (
        .min_i   (shifted),
        .sub_i   (trial),
        .diff_o  (diff),
        .borrow_o(borrow)
    );

    assign qbit_o = ~borrow;
    assign rem_o  = qbit_o ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];

    // R4: a kept difference always fits back into WIDTH bits.
    always_comb begin
        if (active_i && qbit_o) begin
            a_r4_trial_fits: assert (diff[WIDTH] == 1'b0);
        end
    end

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_div_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o,
    output logic dbz_o
);
    import udiv_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

    typedef struct packed {
        ctl_state_e    state;
        logic [CW-1:0] cnt;
        logic          done;
        logic          dbz;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic accept;

    assign accept = start_i && (ctl_q.state == CTL_IDLE);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (ctl_q.state == CTL_RUN) begin
            if (ctl_q.cnt == '0) begin
                ctl_d.state = CTL_IDLE;
                ctl_d.done  = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end else if (accept) begin
            ctl_d.dbz = zero_div_i;
            if (zero_div_i) begin
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.state = CTL_RUN;
                ctl_d.cnt   = LAST_CNT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{state: CTL_IDLE, cnt: '0, done: 1'b0, dbz: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign load_o = accept;
    assign step_o = (ctl_q.state == CTL_RUN);
    assign busy_o = (ctl_q.state == CTL_RUN);
    assign done_o = ctl_q.done;
    assign dbz_o  = ctl_q.dbz;

    a_r3_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o);

    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (ctl_q.cnt <= LAST_CNT));

    a_r8_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbz_o) |-> done_o);

    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dbz_o) |-> $past(busy_o));

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             div_zero_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dvd;
        logic [WIDTH-1:0] dvs;
        logic [WIDTH-1:0] quo;
        logic [WIDTH-1:0] rem;
    } dp_t;

    dp_t  dp_d, dp_q;
    logic load;
    logic step;
    logic zero_div;
    logic qbit;
    logic [WIDTH-1:0] rem_next;

    assign zero_div = (divisor_i == '0);

    udiv_ctrl #(.WIDTH(WIDTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .zero_div_i(zero_div),
        .load_o    (load),
        .step_o    (step),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .dbz_o     (div_zero_o)
    );

    udiv_stage #(.WIDTH(WIDTH)) i_stage (
        .active_i (step),
        .rem_i    (dp_q.rem),
        .msb_i    (dp_q.dvd[WIDTH-1]),
        .divisor_i(dp_q.dvs),
        .rem_o    (rem_next),
        .qbit_o   (qbit)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            if (zero_div) begin
                dp_d.quo = '1;
                dp_d.rem = dividend_i;
                dp_d.dvd = '0;
                dp_d.dvs = '0;
            end else begin
                dp_d.dvd = dividend_i;
                dp_d.dvs = divisor_i;
                dp_d.quo = '0;
                dp_d.rem = '0;
            end
        end else if (step) begin
            dp_d.dvd = {dp_q.dvd[WIDTH-2:0], 1'b0};
            dp_d.rem = rem_next;
            dp_d.quo = {dp_q.quo[WIDTH-2:0], qbit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient_o  = dp_q.quo;
    assign remainder_o = dp_q.rem;

    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (dp_q.rem < dp_q.dvs));

    a_r6_quotient_shifts: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (quotient_o[WIDTH-1:1] == $past(quotient_o[WIDTH-2:0])));

    a_r7_cleared_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !zero_div) |=> (quotient_o == '0 && remainder_o == '0));

    a_r8_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && div_zero_o) |-> (quotient_o == '1 && !busy_o));

endmodule

// File: tb/test_restoring_divider.sv
module test_restoring_divider;

    localparam int W    = 5;
    localparam int SPAN = 1 << W;
    localparam int ONES = SPAN - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dvd = '0;
    logic [W-1:0] dvs = '0;
    logic         busy, done, dz;
    logic [W-1:0] quo, rem;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    restoring_divider #(.WIDTH(W)) i_restoring_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .dividend_i (dvd),
        .divisor_i  (dvs),
        .busy_o     (busy),
        .done_o     (done),
        .div_zero_o (dz),
        .quotient_o (quo),
        .remainder_o(rem)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && dz == 0, "R1", "flags in reset",
            int'({busy, done, dz}), 0);
        chk(quo == 0 && rem == 0, "R1", "results in reset", int'({quo, rem}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && dz == 0 && quo == 0 && rem == 0, "R1",
            "state after reset", int'({busy, done, dz, quo, rem}), 0);
    endtask

    // Full operation with per-step checks.
    task automatic run_div(input int a, input int b);
        @(negedge clk);
        start = 1'b1;
        dvd   = W'(a);
        dvs   = W'(b);
        @(negedge clk);
        start = 1'b0;
        if (b == 0) begin
            chk(done == 1 && dz == 1 && busy == 0, "R8", "zero flags",
                int'({done, dz, busy}), 6);
            chk(int'(quo) == ONES, "R8", "zero quotient", int'(quo), ONES);
            chk(int'(rem) == a, "R8", "zero remainder", int'(rem), a);
            @(negedge clk);
            chk(done == 0, "R5", "zero done width", int'(done), 0);
            return;
        end
        chk(busy == 1 && done == 0 && dz == 0, "R3", "busy after accept",
            int'({busy, done, dz}), 4);
        chk(quo == 0 && rem == 0, "R7", "cleared on accept", int'({quo, rem}), 0);
        for (int i = 1; i < W; i++) begin
            @(negedge clk);
            chk(busy == 1 && done == 0, "R3", "busy mid-run", int'({busy, done}), 2);
            chk(int'(quo) == (a >> (W - i)) / b, "R6", "partial quotient",
                int'(quo), (a >> (W - i)) / b);
            chk(int'(rem) == (a >> (W - i)) % b, "R6", "partial remainder",
                int'(rem), (a >> (W - i)) % b);
        end
        @(negedge clk);
        chk(done == 1 && busy == 0 && dz == 0, "R3", "done timing",
            int'({done, busy, dz}), 4);
        chk(int'(quo) == a / b, "R4", "quotient", int'(quo), a / b);
        chk(int'(rem) == a % b, "R4", "remainder", int'(rem), a % b);
        chk(int'(quo) * b + int'(rem) == a && int'(rem) < b, "R4", "identity",
            int'(quo) * b + int'(rem), a);
        @(negedge clk);
        chk(done == 0, "R5", "done width", int'(done), 0);
    endtask

    task automatic t_example;
        run_div(29, 3);
        chk(quo == 5'b01001 && rem == 5'b00010, "R4", "29/3 example",
            int'({quo, rem}), int'({5'b01001, 5'b00010}));
    endtask

    task automatic t_start_while_busy;
        @(negedge clk);
        start = 1'b1; dvd = 5'd29; dvs = 5'd3;
        @(negedge clk);              // accepted
        start = 1'b0;
        @(negedge clk);              // 1 step
        @(negedge clk);              // 2 steps
        start = 1'b1; dvd = 5'd7; dvs = 5'd1;
        @(negedge clk);              // 3 steps
        start = 1'b0;
        @(negedge clk);              // 4 steps
        @(negedge clk);              // 5 steps
        chk(done == 1, "R2", "done time kept", int'(done), 1);
        chk(quo == 5'd9 && rem == 5'd2, "R2", "result unchanged",
            int'({quo, rem}), int'({5'd9, 5'd2}));
        @(negedge clk);
        chk(busy == 0 && done == 0, "R2", "no late restart", int'({busy, done}), 0);
    endtask

    task automatic t_hold_and_flag_clear;
        run_div(5, 0);
        repeat (3) @(negedge clk);
        chk(dz == 1 && int'(quo) == ONES && rem == 5'd5 && done == 0, "R9",
            "zero result held", int'({dz, quo, rem}), int'({1'b1, 5'd31, 5'd5}));
        run_div(22, 4);
        repeat (3) @(negedge clk);
        chk(quo == 5'd5 && rem == 5'd2 && dz == 0 && busy == 0, "R9",
            "result held, flag cleared", int'({dz, quo, rem}), int'({1'b0, 5'd5, 5'd2}));
    endtask

    task automatic t_sweep;
        for (int a = 0; a < SPAN; a++) begin
            for (int b = 0; b < SPAN; b++) begin
                run_div(a, b);
            end
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_start_while_busy();
        t_hold_and_flag_clear();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule